// File: doc/BRIEF.md
# Response Read Sequencer

This block is a host-side bus master that drains a command response from a FIFO-style device interface reached over a byte-wide register bus. Each bus read is a request/acknowledge exchange. The sequencer holds `bus_req_o` and `bus_addr_o` steady until the device raises `bus_ack_i` for one cycle, and the read byte arrives on `bus_rdata_i` in that same cycle.

A transfer begins with a `start_i` pulse and a byte budget. For every burst, the sequencer first polls the device status byte until it shows both "status valid" and "data available". It then reads a 16-bit burst count as two byte reads, and retries while that count is zero. Next it pulls the smaller of the remaining budget and the burst count from the data port, one byte per read. Each byte leaves on a stream port with a one-cycle valid strobe.

In header mode the transfer stops after the first burst that brings the total to six bytes or more, which is enough to learn the response length. Every transfer ends with a one-cycle `done_o`, the number of bytes delivered, and an error flag. When the error flag is set, the status byte that was last observed comes with it. Both wait loops are bounded by cycle-count limits.

Top module: `resp_read_seq`

## Requirements
- R1: After reset the block is idle: `bus_req_o`, `rx_valid_o` and `done_o` are 0.
- R2: Before each burst the block reads the status register (`STS_ADDR`) and does not read the burst count until a status byte with bit 7 (valid) and bit 4 (data available) both set has been returned. A request holds its address until it is acknowledged.
- R3: If no ready status is seen within `WAIT_TMO` cycles of entering the poll, the transfer ends with `done_o`=1, `err_o`=1 and `err_status_o` equal to the last status byte read.
- R4: The burst count is read from `STS_ADDR+1` (low byte) and then `STS_ADDR+2` (high byte) and combined little-endian. A zero result re-reads both bytes without a new status poll.
- R5: If the burst count is still zero `BURST_TMO` cycles after the ready status, the transfer ends with `err_o`=1 and `err_status_o` equal to the ready status byte.
- R6: Each burst reads exactly min(remaining budget, burst count) bytes from `DATA_ADDR`. The block never reads more data bytes than the budget.
- R7: Each data byte appears on `rx_data_o` with `rx_valid_o` high for one cycle, the cycle after its acknowledge, in read order. `count_o` increments with each byte.
- R8: In full mode the transfer ends when the budget is consumed. `done_o` is high for one cycle with `err_o`=0, `count_o` equal to the budget, and `bus_req_o` low.
- R9: In header mode (`hdr_only_i`=1) the transfer ends after the first burst whose completion brings the total to at least 6 bytes, or earlier if the budget runs out.
- R10: A start with a budget of 0 gives `done_o` with `count_o`=0 and makes no bus access.
- R11: A `start_i` pulse while a transfer is in progress has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| len_i | input | LEN_W | Byte budget of the transfer |
| hdr_only_i | input | 1 | Stop early once 6 or more bytes are in |
| bus_req_o | output | 1 | Register read request |
| bus_addr_o | output | ADDR_W | Register address of the request |
| bus_rdata_i | input | 8 | Read byte, valid with acknowledge |
| bus_ack_i | input | 1 | Request completed |
| rx_valid_o | output | 1 | Data byte strobe |
| rx_data_o | output | 8 | Data byte |
| done_o | output | 1 | Transfer finished (one cycle) |
| count_o | output | LEN_W | Bytes delivered, valid with done |
| err_o | output | 1 | Transfer ended by a timeout (with done) |
| err_status_o | output | 8 | Last status byte at the timeout |

## Verification
The assertions watch, on every cycle, the local rules of the bus and the output stream. A request keeps its address until acknowledged, a byte strobe follows only a data-port acknowledge and advances the count by one, `done_o` is a single-cycle pulse with the bus released, and the error flag only rides on `done_o`. Only the bench scenarios can show the transfer as a whole: that the burst counts are combined little-endian, that the number of bursts and data reads matches the budget arithmetic in both modes, that no burst-count read comes before a ready status, that both timeouts report the right status byte, and that a start mid-transfer is ignored.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_CNT_LO,
    ST_CNT_HI,
    ST_DATA
  } rrs_state_e;

  // status byte bits that must both be set before a burst
  localparam logic [7:0] STS_READY_MASK = 8'h90;
endpackage

// File: rtl/rrs_rst_sync.sv
module rrs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rrs_timer.sv
module rrs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)          cnt_d = '0;
    else if (~&cnt_q)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rrs_tally.sv
module rrs_tally #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             burst_ld_i,
  input  logic [LEN_W-1:0] burst_i,
  input  logic             step_i,
  output logic [LEN_W-1:0] remain_o,
  output logic [LEN_W-1:0] burst_left_o,
  output logic [LEN_W-1:0] total_o
);
  logic [LEN_W-1:0] remain_q, remain_d;
  logic [LEN_W-1:0] bleft_q, bleft_d;
  logic [LEN_W-1:0] total_q, total_d;
  logic             upd;

  always_comb begin
    remain_d = remain_q;
    bleft_d  = bleft_q;
    total_d  = total_q;
    if (load_i) begin
      remain_d = len_i;
      bleft_d  = '0;
      total_d  = '0;
    end else if (burst_ld_i) begin
      bleft_d  = burst_i;
    end else if (step_i) begin
      remain_d = remain_q - 1'b1;
      bleft_d  = bleft_q - 1'b1;
      total_d  = total_q + 1'b1;
    end
  end

  assign upd = load_i | burst_ld_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      bleft_q  <= '0;
      total_q  <= '0;
    end else if (upd) begin
      remain_q <= remain_d;
      bleft_q  <= bleft_d;
      total_q  <= total_d;
    end
  end

  assign remain_o     = remain_q;
  assign burst_left_o = bleft_q;
  assign total_o      = total_q;
endmodule

// File: rtl/resp_read_seq.sv
module resp_read_seq
  import rrs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h024,
  parameter int MAX_LEN   = 1024,
  parameter int HDR_MIN   = 6,
  parameter int WAIT_TMO  = 24_000_000,
  parameter int BURST_TMO = 400_000,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              hdr_only_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              rx_valid_o,
  output logic [7:0]        rx_data_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  count_o,
  output logic              err_o,
  output logic [7:0]        err_status_o
);
  localparam int TMO_TOP = (WAIT_TMO > BURST_TMO) ? WAIT_TMO : BURST_TMO;
  localparam int TMR_W   = $clog2(TMO_TOP + 1);

  logic srst_n;
  rrs_state_e state_q, state_d;
  logic       hdr_q;
  logic [7:0] lo_q, sts_q, errsts_d, errsts_q;
  logic       rxv_q, done_q, err_q;
  logic [7:0] rxd_q;

  logic             tmr_clear;
  logic [TMR_W-1:0] tmr;
  logic             t_load, b_load, t_step, lo_en, sts_en, fin, fin_err;
  logic [LEN_W-1:0] remain, bleft, total, burst_take;
  logic [15:0]      burst16;
  logic             sts_ready;

  rrs_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  rrs_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(srst_n), .clear_i(tmr_clear), .cnt_o(tmr)
  );

  rrs_tally #(.LEN_W(LEN_W)) u_tally (
    .clk(clk), .rst_n(srst_n),
    .load_i(t_load), .len_i(len_i),
    .burst_ld_i(b_load), .burst_i(burst_take),
    .step_i(t_step),
    .remain_o(remain), .burst_left_o(bleft), .total_o(total)
  );

  assign burst16    = {bus_rdata_i, lo_q};
  assign burst_take = (32'(burst16) > 32'(remain)) ? remain : LEN_W'(burst16);
  assign sts_ready  = (bus_rdata_i & STS_READY_MASK) == STS_READY_MASK;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    tmr_clear = 1'b0;
    t_load    = 1'b0;
    b_load    = 1'b0;
    t_step    = 1'b0;
    lo_en     = 1'b0;
    sts_en    = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    errsts_d  = errsts_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        t_load    = 1'b1;
        tmr_clear = 1'b1;
        if (len_i == '0) fin = 1'b1;
        else             state_d = ST_POLL;
      end
      ST_POLL: if (bus_ack_i) begin
        sts_en = 1'b1;
        if (sts_ready) begin
          state_d   = ST_CNT_LO;
          tmr_clear = 1'b1;
        end else if (32'(tmr) >= WAIT_TMO) begin
          fin      = 1'b1;
          fin_err  = 1'b1;
          errsts_d = bus_rdata_i;
        end
      end
      ST_CNT_LO: if (bus_ack_i) begin
        lo_en   = 1'b1;
        state_d = ST_CNT_HI;
      end
      ST_CNT_HI: if (bus_ack_i) begin
        if (burst16 != 16'h0) begin
          b_load  = 1'b1;
          state_d = ST_DATA;
        end else if (32'(tmr) >= BURST_TMO) begin
          fin      = 1'b1;
          fin_err  = 1'b1;
          errsts_d = sts_q;
        end else begin
          state_d = ST_CNT_LO;
        end
      end
      ST_DATA: if (bus_ack_i) begin
        t_step = 1'b1;
        if (bleft == LEN_W'(1)) begin
          if (remain == LEN_W'(1)) begin
            fin = 1'b1;
          end else if (hdr_q && (32'(total) + 1 >= HDR_MIN)) begin
            fin = 1'b1;
          end else begin
            state_d   = ST_POLL;
            tmr_clear = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_comb begin
    unique case (state_q)
      ST_CNT_LO: bus_addr_o = STS_ADDR + ADDR_W'(1);
      ST_CNT_HI: bus_addr_o = STS_ADDR + ADDR_W'(2);
      ST_DATA:   bus_addr_o = DATA_ADDR;
      default:   bus_addr_o = STS_ADDR;
    endcase
  end
  assign bus_req_o = (state_q != ST_IDLE);

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= ST_IDLE;
      hdr_q    <= 1'b0;
      lo_q     <= '0;
      sts_q    <= '0;
      errsts_q <= '0;
      rxv_q    <= 1'b0;
      rxd_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      rxv_q    <= t_step;
      done_q   <= fin;
      err_q    <= fin_err;
      errsts_q <= errsts_d;
      if (t_load) hdr_q <= hdr_only_i;
      if (lo_en)  lo_q  <= bus_rdata_i;
      if (sts_en) sts_q <= bus_rdata_i;
      if (t_step) rxd_q <= bus_rdata_i;
    end
  end

  assign rx_valid_o   = rxv_q;
  assign rx_data_o    = rxd_q;
  assign done_o       = done_q;
  assign count_o      = total;
  assign err_o        = err_q;
  assign err_status_o = errsts_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h024,
  parameter int LEN_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic              rx_valid_o,
  input logic              done_o,
  input logic [LEN_W-1:0]  count_o,
  input logic              err_o
);
  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)));

  assert_strobe_follows_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(bus_req_o && bus_ack_i && (bus_addr_o == DATA_ADDR)));

  assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (count_o == LEN_W'($past(count_o) + 1'b1)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_bus_free_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o);

  assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

bind resp_read_seq rrs_checker #(
  .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .LEN_W(LEN_W)
) u_rrs_checker (
  .clk(clk), .rst_n(rst_n),
  .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i),
  .rx_valid_o(rx_valid_o), .done_o(done_o), .count_o(count_o), .err_o(err_o)
);

// File: tb/test_resp_read_seq.sv
module test_resp_read_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STS  = 12'h018;
  localparam logic [11:0] DATP = 12'h024;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic hdr = 1'b0;
  logic bus_req, bus_ack = 1'b0;
  logic [11:0] bus_addr;
  logic [7:0] bus_rdata = '0;
  logic rx_valid, done, err;
  logic [7:0] rx_data, err_status;
  logic [LEN_W-1:0] count;

  int checks = 0, errors = 0, cycles = 0;
  // device model state
  int m_nr = 0, m_zn = 0, m_bval = 1;
  int poll_cnt = 0, zero_cnt = 0, didx = 0, viol = 0, nz_bursts = 0;
  bit ready_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_read_seq #(.WAIT_TMO(30), .BURST_TMO(20)) i_resp_read_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len), .hdr_only_i(hdr),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .done_o(done), .count_o(count), .err_o(err), .err_status_o(err_status)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  // register-bus responder: acknowledges one cycle after each request
  always @(negedge clk) begin
    if (!rst_n) bus_ack <= 1'b0;
    else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_addr == STS) begin
        if (poll_cnt < m_nr) begin bus_rdata <= 8'h81; poll_cnt <= poll_cnt + 1; end
        else begin bus_rdata <= 8'h9A; ready_flag <= 1'b1; end
      end else if (bus_addr == STS + 12'd1) begin
        if (!ready_flag) viol <= viol + 1;
        bus_rdata <= (zero_cnt < m_zn) ? 8'h00 : 8'(m_bval & 255);
      end else if (bus_addr == STS + 12'd2) begin
        if (!ready_flag) viol <= viol + 1;
        if (zero_cnt < m_zn) begin bus_rdata <= 8'h00; zero_cnt <= zero_cnt + 1; end
        else begin
          bus_rdata <= 8'((m_bval >> 8) & 255);
          zero_cnt <= 0; poll_cnt <= 0; ready_flag <= 1'b0; nz_bursts <= nz_bursts + 1;
        end
      end else if (bus_addr == DATP) begin
        bus_rdata <= pat(didx); didx <= didx + 1;
      end else begin
        bus_rdata <= 8'hEE; viol <= viol + 1;
      end
    end else bus_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int blen, input int bval, input bit hmode, input int nr,
                     input int zn, input bit poke, input bit exp_err,
                     input logic [7:0] exp_sts, input string tag);
    int cnt_exp = 0, bursts_exp = 0, rx_idx = 0, bad = 0, it = 0;
    if (!exp_err) begin
      while (cnt_exp < blen) begin
        cnt_exp += ((blen - cnt_exp) < bval) ? (blen - cnt_exp) : bval;
        bursts_exp++;
        if (hmode && cnt_exp >= 6) break;
      end
    end
    @(negedge clk);
    m_nr = nr; m_zn = zn; m_bval = bval;
    poll_cnt = 0; zero_cnt = 0; didx = 0; viol = 0; nz_bursts = 0; ready_flag = 0;
    start = 1'b1; len = LEN_W'(blen); hdr = hmode;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (rx_valid) begin
        if (rx_data != pat(rx_idx)) bad++;
        rx_idx++;
      end
      if (done) break;
      it++;
      // R11: a second start mid-transfer must change nothing
      if (poke && it == 6) begin start = 1'b1; len = LEN_W'(3); hdr = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(int'(count) == cnt_exp, tag, "count", int'(count), cnt_exp);
    chk(err == exp_err, tag, "err flag", int'(err), int'(exp_err));
    if (exp_err) chk(err_status == exp_sts, tag, "err status", int'(err_status), int'(exp_sts));
    chk(bad == 0 && rx_idx == cnt_exp, "R7", "stream bytes", rx_idx - bad, cnt_exp);
    chk(didx == cnt_exp, "R6", "data port reads", didx, cnt_exp);
    if (!exp_err) chk(nz_bursts == bursts_exp, "R4", "bursts", nz_bursts, bursts_exp);
    chk(viol == 0, "R2", "count read before ready", viol, 0);
    @(negedge clk);
    chk(!done && !bus_req, "R8", "done pulse then idle", int'(done), 0);
  endtask

  initial begin
    int lens[7]   = '{0, 1, 5, 6, 7, 10, 13};
    int bursts[5] = '{1, 3, 4, 8, 256};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_req && !done && !rx_valid, "R1", "idle after reset", int'(bus_req), 0);
    for (int li = 0; li < 7; li++)
      for (int bi = 0; bi < 5; bi++)
        for (int h = 0; h < 2; h++)
          run(lens[li], bursts[bi], h[0], (li + bi) % 3, (li + bi + h) % 3, 1'b0, 1'b0, 8'h00,
              (lens[li] == 0) ? "R10" : (h != 0 ? "R9" : "R8"));
    // R4: little-endian combine decides the number of bursts
    run(700, 16'h0201, 1'b0, 0, 0, 1'b0, 1'b0, 8'h00, "R4");
    run(1024, 16'h0300, 1'b0, 1, 1, 1'b0, 1'b0, 8'h00, "R4");
    // R3: status never ready
    run(10, 4, 1'b0, 100000, 0, 1'b0, 1'b1, 8'h81, "R3");
    // R5: burst count stays zero
    run(10, 4, 1'b0, 0, 100000, 1'b0, 1'b1, 8'h9A, "R5");
    // R11: start while busy ignored
    run(13, 1, 1'b0, 0, 0, 1'b1, 1'b0, 8'h00, "R11");
    run(10, 4, 1'b1, 1, 0, 1'b1, 1'b0, 8'h00, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule